// File: doc/BRIEF.md
# Memory-Mapped SPI Flash Read Engine

This block turns a read request from an on-chip bus into a complete SPI flash read frame. A 32-bit setup word describes the frame: the read opcode, how many address bytes follow it, how many dummy clocks come next, and whether the data phase uses one, two or four lines. A mode-switch input gives the flash pins to this engine. When the switch is clear, the pins belong to a separate command engine, and the block passes that engine's pins through unchanged.

Each accepted request produces one frame. Chip select falls, then the opcode and the address go out on IO0, most significant bit first. The dummy clocks follow with every line released. The data phase captures 32 bits, which the block returns as a little-endian word with a one-cycle ready pulse. SCLK idles low, the engine changes its outputs while SCLK is low, and it samples the flash on the rising edge. A half period of SCLK lasts HALF_DIV system clocks. A request that arrives while the switch is clear, or while the setup word is all zeros, gets an error response and produces no frame.

Top module: `xip_read_engine`

## Requirements
- R1: After reset the engine is idle: chip select high, SCLK low, ready and error low, and the flash pins follow the command path while the switch input is low.
- R2: Setup bits 7:0 give the opcode. It is sent on IO0, MSB first, during the first 8 SCLK cycles of the frame, with only IO0 driven.
- R3: Setup bits 9:8 give the number of address bytes (0 to 3). The low-order bytes of the request address are sent on IO0 after the opcode, MSB first.
- R4: The number of dummy SCLK cycles is 8 times setup bits 11:10 plus setup bits 28:24. No line is driven during the dummy cycles or the data phase.
- R5: Setup bits 13:12 give the data width. Value 0 is single (sampled on IO1). Value 1 is dual, with IO1 carrying the earlier bit. Value 3 is quad, with IO3 carrying the earliest bit. Value 2 is treated as single.
- R6: The first received data byte appears in read data bits 7:0 and the fourth in bits 31:24. Within each byte, bits arrive MSB first.
- R7: A frame lasts N = 8 + 8·addr_bytes + dummy + 32/lanes SCLK cycles. Ready pulses for exactly one cycle, 2·HALF_DIV·N clock edges after the edge that accepts the request, with error low.
- R8: A request while the switch input is low, or while the setup word is zero, gives ready and error high in the cycle after the sampling edge. Read data is zero and chip select never falls.
- R9: A request that arrives while a frame is in progress is ignored. No second frame and no extra ready pulse follow.
- R10: With the switch low and the engine idle, the flash SCLK, chip select, IO outputs and IO enables equal the command-path inputs. With the switch high, the engine drives the flash pins.
- R11: Setup bits 23:16 (the write opcode) and bits 15:14 and 31:29 have no effect on a read.
- R12: Between frames, chip select is high and SCLK is low, and SCLK toggles only while chip select is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| map_en | input | 1 | Mode switch: 1 gives the flash pins to this engine |
| setup_word | input | 32 | Read frame setup word |
| bus_req | input | 1 | Read request strobe |
| bus_addr | input | ADDR_W | Read byte address |
| bus_rdata | output | 32 | Read data, valid while bus_ready is high |
| bus_ready | output | 1 | One-cycle completion pulse |
| bus_err | output | 1 | Error flag, valid with bus_ready |
| cmd_sclk | input | 1 | SCLK from the command engine |
| cmd_cs_n | input | 1 | Chip select from the command engine |
| cmd_io_out | input | 4 | IO output values from the command engine |
| cmd_io_oe | input | 4 | IO output enables from the command engine |
| fl_sclk | output | 1 | Flash SCLK |
| fl_cs_n | output | 1 | Flash chip select, active low |
| fl_io_out | output | 4 | Flash IO output values |
| fl_io_oe | output | 4 | Flash IO output enables |
| fl_io_in | input | 4 | Flash IO input values |

## Verification
A successful read completes 2·HALF_DIV·N edges after the accepting edge, where N follows from the setup fields. An error response comes on the accepting edge itself. The bench drives each request at a falling clock edge and counts falling edges until ready appears. The count must equal the computed value exactly, so a result that arrives early or late is reported. The flash model in the bench counts SCLK rising edges. It drives data from that count, so its data is already stable when the engine samples on the rising edge. The model records the opcode, the address and the frame length at chip-select release, and the bench compares them in the cycle where ready is seen.

// File: rtl/xip_pkg.sv
// Shared types for the memory-mapped flash read engine.
// Assumes a 4-line flash interface and a frame of at most 255 SCLK cycles.
package xip_pkg;

    localparam int IO_LANES = 4;
    localparam int CYC_W    = 8;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_LOW,
        SQ_HIGH,
        SQ_FIN,
        SQ_ERR
    } seq_state_t;

    // Decoded form of the setup word
    typedef struct packed {
        logic [7:0] opcode;
        logic [1:0] addr_bytes;
        logic [5:0] dummy_cyc;
        logic [2:0] lanes;
        logic       active;
    } rd_cfg_t;

endpackage

// File: rtl/xip_setup_decode.sv
// Decodes the 32-bit setup word into frame parameters.
// Purely combinational. Assumes the word is stable while a request is accepted.
// Fields not used for reads (write opcode, spare bits) are ignored.
module xip_setup_decode
    import xip_pkg::*;
(
    input  logic [31:0] setup_word,
    output rd_cfg_t     cfg
);

    logic [1:0] dummy_bytes;
    logic [4:0] dummy_bits;
    logic [1:0] width_code;
    logic       unused_fields;

    assign dummy_bytes   = setup_word[11:10];
    assign dummy_bits    = setup_word[28:24];
    assign width_code    = setup_word[13:12];
    assign unused_fields = ^{setup_word[31:29], setup_word[23:14]};

    // Map the width code to a lane count and total the dummy clocks
    always_comb begin
        cfg.opcode     = setup_word[7:0];
        cfg.addr_bytes = setup_word[9:8];
        cfg.dummy_cyc  = {1'b0, dummy_bytes, 3'b000} + {1'b0, dummy_bits};
        case (width_code)
            2'd1:    cfg.lanes = 3'd2;
            2'd3:    cfg.lanes = 3'd4;
            default: cfg.lanes = 3'd1;
        endcase
        cfg.active     = |setup_word;
    end

endmodule

// File: rtl/xip_frame_seq.sv
// Runs one SPI flash read frame per accepted request.
// Mode 0: SCLK idles low, outputs change while SCLK is low, and input is
// sampled as SCLK rises. Requests are accepted only while idle. The
// configuration is latched at acceptance. Assumes DATA_W is a multiple of 8.
module xip_frame_seq
    import xip_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int DATA_W   = 32,
    parameter int HALF_DIV = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                map_en,
    input  rd_cfg_t             cfg_in,
    input  logic                req,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [IO_LANES-1:0] io_in,
    output logic                sclk,
    output logic                cs_n,
    output logic [IO_LANES-1:0] io_out,
    output logic [IO_LANES-1:0] io_oe,
    output logic [DATA_W-1:0]   rdata,
    output logic                ready,
    output logic                err,
    output logic                busy
);

    localparam int HC_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int NB   = DATA_W / 8;
    localparam int TX_W = 32;

    seq_state_t       state_q;
    rd_cfg_t          cfg_q;
    logic [TX_W-1:0]  tx_q;
    logic [DATA_W-1:0] rx_q;
    logic [CYC_W-1:0] cyc_q;
    logic [HC_W-1:0]  hcnt_q;
    logic             sclk_q;
    logic             cs_n_q;

    logic [23:0]      addr24;
    logic [4:0]       addr_shift;
    logic [CYC_W-1:0] addr_end;
    logic [CYC_W-1:0] dummy_end;
    logic [CYC_W-1:0] data_cyc;
    logic [CYC_W-1:0] total_cyc;
    logic             in_shift;
    logic             in_data;
    logic             half_end;
    logic             last_cyc;
    logic             unused_cfg;

    assign addr24     = 24'(addr);
    assign addr_shift = 5'd24 - {cfg_in.addr_bytes, 3'b000};
    assign unused_cfg = cfg_q.active;

    // Phase boundaries of the frame in progress
    always_comb begin
        addr_end  = 8'd8 + {3'b000, cfg_q.addr_bytes, 3'b000};
        dummy_end = addr_end + {2'b00, cfg_q.dummy_cyc};
        case (cfg_q.lanes)
            3'd4:    data_cyc = 8'(DATA_W / 4);
            3'd2:    data_cyc = 8'(DATA_W / 2);
            default: data_cyc = 8'(DATA_W);
        endcase
        total_cyc = dummy_end + data_cyc;
        in_shift  = (cyc_q < addr_end);
        in_data   = (cyc_q >= dummy_end);
        half_end  = (hcnt_q == HC_W'(HALF_DIV - 1));
        last_cyc  = (cyc_q == total_cyc - 8'd1);
    end

    // Frame state machine, SCLK generation, shifting and sampling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            cfg_q   <= '0;
            tx_q    <= '0;
            rx_q    <= '0;
            cyc_q   <= '0;
            hcnt_q  <= '0;
            sclk_q  <= 1'b0;
            cs_n_q  <= 1'b1;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    if (req) begin
                        if (map_en && cfg_in.active) begin
                            cfg_q   <= cfg_in;
                            tx_q    <= {cfg_in.opcode, addr24 << addr_shift};
                            cyc_q   <= '0;
                            hcnt_q  <= '0;
                            cs_n_q  <= 1'b0;
                            state_q <= SQ_LOW;
                        end else begin
                            rx_q    <= '0;
                            state_q <= SQ_ERR;
                        end
                    end
                end
                SQ_LOW: begin
                    if (half_end) begin
                        hcnt_q  <= '0;
                        sclk_q  <= 1'b1;
                        state_q <= SQ_HIGH;
                        if (in_data) begin
                            case (cfg_q.lanes)
                                3'd4:    rx_q <= {rx_q[DATA_W-5:0], io_in[3], io_in[2], io_in[1], io_in[0]};
                                3'd2:    rx_q <= {rx_q[DATA_W-3:0], io_in[1], io_in[0]};
                                default: rx_q <= {rx_q[DATA_W-2:0], io_in[1]};
                            endcase
                        end
                    end else begin
                        hcnt_q <= hcnt_q + HC_W'(1);
                    end
                end
                SQ_HIGH: begin
                    if (half_end) begin
                        hcnt_q <= '0;
                        sclk_q <= 1'b0;
                        if (last_cyc) begin
                            cs_n_q  <= 1'b1;
                            state_q <= SQ_FIN;
                        end else begin
                            cyc_q   <= cyc_q + 8'd1;
                            state_q <= SQ_LOW;
                            if (in_shift) begin
                                tx_q <= {tx_q[TX_W-2:0], 1'b0};
                            end
                        end
                    end else begin
                        hcnt_q <= hcnt_q + HC_W'(1);
                    end
                end
                SQ_FIN:  state_q <= SQ_IDLE;
                SQ_ERR:  state_q <= SQ_IDLE;
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // Single-line output during opcode and address; all lines released after
    always_comb begin
        io_out = '0;
        io_oe  = '0;
        if (!cs_n_q && in_shift) begin
            io_out[0] = tx_q[TX_W-1];
            io_oe[0]  = 1'b1;
        end
    end

    // Little-endian assembly: the first byte received lands in bits 7:0
    for (genvar b = 0; b < NB; b++) begin : g_swap
        assign rdata[8*b +: 8] = rx_q[DATA_W-8-8*b +: 8];
    end

    assign sclk  = sclk_q;
    assign cs_n  = cs_n_q;
    assign ready = (state_q == SQ_FIN) || (state_q == SQ_ERR);
    assign err   = (state_q == SQ_ERR);
    assign busy  = (state_q != SQ_IDLE);

    AST_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_IDLE) |-> cs_n_q); // R12
    AST_SCLK_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_q |-> !sclk_q); // R12
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready); // R7
    AST_ERR_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (cs_n_q && $past(cs_n_q))); // R8
    AST_CYC_WITHIN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_q |-> (cyc_q < total_cyc)); // R7
    AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == SQ_LOW || state_q == SQ_HIGH) && req) |=> (state_q != SQ_ERR)); // R9

endmodule

// File: rtl/xip_pin_mux.sv
// Selects the flash pin owner: the read engine or the command path.
// Purely combinational. The caller keeps the engine selected while a
// frame is in progress, so a switch change takes effect between frames.
module xip_pin_mux
    import xip_pkg::*;
(
    input  logic                sel_eng,
    input  logic                eng_sclk,
    input  logic                eng_cs_n,
    input  logic [IO_LANES-1:0] eng_io_out,
    input  logic [IO_LANES-1:0] eng_io_oe,
    input  logic                cmd_sclk,
    input  logic                cmd_cs_n,
    input  logic [IO_LANES-1:0] cmd_io_out,
    input  logic [IO_LANES-1:0] cmd_io_oe,
    output logic                fl_sclk,
    output logic                fl_cs_n,
    output logic [IO_LANES-1:0] fl_io_out,
    output logic [IO_LANES-1:0] fl_io_oe
);

    assign fl_sclk = sel_eng ? eng_sclk : cmd_sclk;
    assign fl_cs_n = sel_eng ? eng_cs_n : cmd_cs_n;

    // One selector per IO lane
    for (genvar l = 0; l < IO_LANES; l++) begin : g_lane
        assign fl_io_out[l] = sel_eng ? eng_io_out[l] : cmd_io_out[l];
        assign fl_io_oe[l]  = sel_eng ? eng_io_oe[l]  : cmd_io_oe[l];
    end

endmodule

// File: rtl/xip_read_engine.sv
// Top of the memory-mapped flash read engine.
// Decodes the setup word, runs read frames, and shares the flash pins with
// the command path. Assumes bus_req is a strobe and that the requester
// waits for bus_ready before issuing the next read.
module xip_read_engine
    import xip_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int HALF_DIV = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_en,
    input  logic [31:0]       setup_word,
    input  logic              bus_req,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_rdata,
    output logic              bus_ready,
    output logic              bus_err,
    input  logic              cmd_sclk,
    input  logic              cmd_cs_n,
    input  logic [3:0]        cmd_io_out,
    input  logic [3:0]        cmd_io_oe,
    output logic              fl_sclk,
    output logic              fl_cs_n,
    output logic [3:0]        fl_io_out,
    output logic [3:0]        fl_io_oe,
    input  logic [3:0]        fl_io_in
);

    rd_cfg_t    cfg;
    logic       eng_sclk;
    logic       eng_cs_n;
    logic [3:0] eng_io_out;
    logic [3:0] eng_io_oe;
    logic       eng_busy;

    xip_setup_decode u_decode (
        .setup_word (setup_word),
        .cfg        (cfg)
    );

    xip_frame_seq #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (32),
        .HALF_DIV (HALF_DIV)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .map_en (map_en),
        .cfg_in (cfg),
        .req    (bus_req),
        .addr   (bus_addr),
        .io_in  (fl_io_in),
        .sclk   (eng_sclk),
        .cs_n   (eng_cs_n),
        .io_out (eng_io_out),
        .io_oe  (eng_io_oe),
        .rdata  (bus_rdata),
        .ready  (bus_ready),
        .err    (bus_err),
        .busy   (eng_busy)
    );

    xip_pin_mux u_mux (
        .sel_eng    (map_en | eng_busy),
        .eng_sclk   (eng_sclk),
        .eng_cs_n   (eng_cs_n),
        .eng_io_out (eng_io_out),
        .eng_io_oe  (eng_io_oe),
        .cmd_sclk   (cmd_sclk),
        .cmd_cs_n   (cmd_cs_n),
        .cmd_io_out (cmd_io_out),
        .cmd_io_oe  (cmd_io_oe),
        .fl_sclk    (fl_sclk),
        .fl_cs_n    (fl_cs_n),
        .fl_io_out  (fl_io_out),
        .fl_io_oe   (fl_io_oe)
    );

endmodule

// File: tb/xip_read_engine_tb_top.sv
// Bench: sweeps every data width, address byte count and several dummy
// settings against a behavioural flash model, then covers errors, busy
// requests and pin sharing.
module xip_read_engine_tb_top;

    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        map_en;
    logic [31:0] setup_word;
    logic        bus_req;
    logic [23:0] bus_addr;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic        bus_err;
    logic        cmd_sclk, cmd_cs_n;
    logic [3:0]  cmd_io_out, cmd_io_oe;
    logic        fl_sclk, fl_cs_n;
    logic [3:0]  fl_io_out, fl_io_oe, fl_io_in;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    xip_read_engine #(.ADDR_W(24), .HALF_DIV(HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .map_en(map_en), .setup_word(setup_word),
        .bus_req(bus_req), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .bus_err(bus_err),
        .cmd_sclk(cmd_sclk), .cmd_cs_n(cmd_cs_n), .cmd_io_out(cmd_io_out),
        .cmd_io_oe(cmd_io_oe), .fl_sclk(fl_sclk), .fl_cs_n(fl_cs_n),
        .fl_io_out(fl_io_out), .fl_io_oe(fl_io_oe), .fl_io_in(fl_io_in)
    );

    // Flash model settings for the current frame
    int          m_pre   = 8;
    int          m_lanes = 1;
    int          m_nab   = 0;
    logic [31:0] m_word  = '0;

    int          cnt = 0;
    int          last_cnt = 0;
    logic [7:0]  op_sh = '0, last_op = '0;
    logic [23:0] ad_sh = '0, last_ad = '0;
    int          frames = 0;

    // Record opcode, address and frame length; close the frame at chip-select release
    always @(posedge fl_sclk or posedge fl_cs_n) begin
        if (fl_cs_n) begin
            if (cnt != 0) begin
                last_cnt <= cnt;
                last_op  <= op_sh;
                last_ad  <= ad_sh;
            end
            cnt <= 0;
        end else begin
            if (cnt < 8) op_sh <= {op_sh[6:0], fl_io_out[0]};
            else if (cnt < 8 + 8*m_nab) ad_sh <= {ad_sh[22:0], fl_io_out[0]};
            cnt <= cnt + 1;
        end
    end

    // Count frame starts
    always @(negedge fl_cs_n) frames++;

    function automatic logic sbit(input logic [31:0] w, input int s);
        if (s > 31) return 1'b0;
        return w[8*(s/8) + 7 - (s%8)];
    endfunction

    // Data phase: bytes go out in ascending order, MSB first, earliest bit on the highest lane
    always_comb begin
        int dc;
        fl_io_in = 4'h0;
        dc = cnt - m_pre;
        if (cnt >= m_pre) begin
            case (m_lanes)
                4: fl_io_in = {sbit(m_word, 4*dc), sbit(m_word, 4*dc+1),
                               sbit(m_word, 4*dc+2), sbit(m_word, 4*dc+3)};
                2: fl_io_in = {2'b00, sbit(m_word, 2*dc), sbit(m_word, 2*dc+1)};
                default: fl_io_in = {2'b00, sbit(m_word, dc), 1'b0};
            endcase
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One read: lat counts edges after the accepting edge until ready is seen
    task automatic do_read(input logic [23:0] a, input bit dbl, output int lat,
                           output logic [31:0] dat, output logic e, output int nrdy);
        lat = 0; nrdy = 0; dat = '0; e = 1'b0;
        @(negedge clk); bus_addr = a; bus_req = 1'b1;
        @(negedge clk); bus_req = 1'b0;
        while (lat < 4000) begin
            if (bus_ready) begin nrdy++; dat = bus_rdata; e = bus_err; break; end
            bus_req = (dbl && lat == 3);
            if (dbl && lat == 3) bus_addr = ~a;
            @(negedge clk); lat++;
        end
        bus_req = 1'b0;
        repeat (8) begin @(negedge clk); if (bus_ready) nrdy++; end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int lat, nrdy, idx, fr0, n, lanes;
        logic [31:0] dat, d2;
        logic e, e2;
        logic [23:0] a, mask;
        rst_n = 1'b0; map_en = 1'b0; setup_word = '0; bus_req = 1'b0; bus_addr = '0;
        cmd_sclk = 1'b0; cmd_cs_n = 1'b1; cmd_io_out = 4'h0; cmd_io_oe = 4'h0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(fl_cs_n && !fl_sclk && !bus_ready && !bus_err, "R1 idle after reset",
            {fl_cs_n, fl_sclk, bus_ready, bus_err}, 4'b1000);
        chk(fl_io_oe == cmd_io_oe, "R1 command path owns pins", fl_io_oe, cmd_io_oe);

        // Sweep of data widths, address bytes and dummy settings
        map_en = 1'b1;
        idx = 0;
        for (int md = 0; md < 4; md++) begin
            for (int nab = 0; nab < 4; nab++) begin
                for (int ndb = 0; ndb < 3; ndb++) begin
                    for (int ex = 0; ex < 2; ex++) begin
                        logic [7:0] op;
                        logic [7:0] wop;
                        int xb;
                        xb = ex * 5;
                        op  = 8'h03 + 8'(idx * 37);
                        if (op == 8'h00) op = 8'h6C;
                        wop = 8'h12 ^ 8'(idx);  // R11: write opcode varied across the sweep
                        setup_word = {3'b000, 5'(xb), wop, 2'b00, 2'(md), 2'(ndb), 2'(nab), op};
                        lanes = (md == 1) ? 2 : ((md == 3) ? 4 : 1);
                        m_pre = 8 + 8*nab + 8*ndb + xb;
                        m_lanes = lanes; m_nab = nab;
                        m_word = 32'hC3A5_0F1E ^ (32'(idx) * 32'h0102_0407);
                        a = 24'h5A_0000 + 24'(idx * 24'h01357);
                        n = m_pre + 32/lanes;
                        do_read(a, 1'b0, lat, dat, e, nrdy);
                        chk(lat == 2*HALF*n, "R7 ready latency", 32'(lat), 32'(2*HALF*n));
                        chk(nrdy == 1 && !e, "R7 single ready, no error", 32'(nrdy), 32'd1);
                        chk(last_op == op, "R2 opcode sent", {24'h0, last_op}, {24'h0, op});
                        mask = (nab == 0) ? 24'h0 : 24'((32'h1 << (8*nab)) - 1);
                        chk((last_ad & mask) == (a & mask), "R3 address bytes",
                            {8'h0, last_ad & mask}, {8'h0, a & mask});
                        chk(last_cnt == n, "R4 frame length incl dummy", 32'(last_cnt), 32'(n));
                        chk(dat == m_word, "R5 R6 data width and byte order", dat, m_word);
                        chk(fl_cs_n && !fl_sclk, "R12 idle between frames", {fl_cs_n, fl_sclk}, 2'b10);
                        idx++;
                    end
                end
            end
        end

        // R11: identical results with different unused fields
        setup_word = {3'b000, 5'd0, 8'h00, 2'b00, 2'd3, 2'd1, 2'd3, 8'h6C};
        m_pre = 8 + 24 + 8; m_lanes = 4; m_nab = 3; m_word = 32'h1234_ABCD;
        do_read(24'h00_0100, 1'b0, lat, dat, e, nrdy);
        setup_word = {3'b111, 5'd0, 8'hFF, 2'b11, 2'd3, 2'd1, 2'd3, 8'h6C};
        do_read(24'h00_0100, 1'b0, n, d2, e2, nrdy);
        chk(dat == d2 && lat == n && d2 == m_word, "R11 write opcode ignored", d2, dat);

        // R9: a request during a frame is ignored
        setup_word = {3'b000, 5'd0, 8'h12, 2'b00, 2'd0, 2'd0, 2'd3, 8'h03};
        m_pre = 32; m_lanes = 1; m_nab = 3; m_word = 32'h0BAD_F00D;
        fr0 = frames;
        do_read(24'hABCDEF, 1'b1, lat, dat, e, nrdy);
        chk(nrdy == 1, "R9 one ready only", 32'(nrdy), 32'd1);
        chk(frames == fr0 + 1, "R9 one frame only", 32'(frames - fr0), 32'd1);
        chk(last_ad == 24'hABCDEF && dat == m_word, "R9 first request served", {8'h0, last_ad}, 32'hABCDEF);

        // R8: switch clear gives an error and no frame
        map_en = 1'b0; fr0 = frames;
        do_read(24'h000010, 1'b0, lat, dat, e, nrdy);
        chk(lat == 0 && e && nrdy == 1, "R8 error when switch clear", {lat[15:0], 8'(nrdy), 7'd0, e}, {16'd0, 8'd1, 8'd1});
        chk(dat == 32'h0 && frames == fr0, "R8 no frame, zero data", dat, 32'h0);
        // R8: zero setup word gives an error
        map_en = 1'b1; setup_word = 32'h0; fr0 = frames;
        do_read(24'h000020, 1'b0, lat, dat, e, nrdy);
        chk(lat == 0 && e && frames == fr0, "R8 error when setup zero", {31'd0, e}, 32'd1);

        // R10: pin sharing
        map_en = 1'b1;
        cmd_sclk = 1'b1; cmd_cs_n = 1'b0; cmd_io_out = 4'hA; cmd_io_oe = 4'h5;
        @(negedge clk);
        chk(fl_cs_n && !fl_sclk && fl_io_oe == 4'h0, "R10 engine owns pins when switch set",
            {fl_cs_n, fl_sclk, fl_io_oe}, 6'b100000);
        map_en = 1'b0;
        @(negedge clk);
        chk({fl_sclk, fl_cs_n, fl_io_out, fl_io_oe} == {cmd_sclk, cmd_cs_n, cmd_io_out, cmd_io_oe},
            "R10 command path passthrough", {fl_sclk, fl_cs_n, fl_io_out, fl_io_oe},
            {cmd_sclk, cmd_cs_n, cmd_io_out, cmd_io_oe});
        cmd_io_out = 4'h3; cmd_io_oe = 4'hF; cmd_sclk = 1'b0;
        @(negedge clk);
        chk(fl_io_out == 4'h3 && fl_io_oe == 4'hF && !fl_sclk, "R10 passthrough second pattern",
            {fl_io_out, fl_io_oe}, 8'h3F);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule